// File: doc/BRIEF.md
# Link Rate and Lane Fallback Controller

This block chooses the link configuration for each try at training a serial display link, and it steps down to a lower configuration when a try fails. When a start request arrives, it takes the rate code and lane field that the sink reports and limits both to what the system can drive. It then runs a series of attempts. For each attempt it resets the PHY and its drive levels, waits a settle period, and starts an external training sequencer. That sequencer answers with a done pulse and two result flags: clock recovery passed (CR) and equalization passed (EQ).

If clock recovery failed, the controller drops the rate by one grade. At the lowest rate it halves the lane count and goes back to the starting rate instead. If clock recovery passed but equalization failed, it keeps the rate and reduces only the lanes. The number of attempts has an upper limit. The final verdict comes out as a one-cycle done pulse. A pass flag and the trained rate and lane count stay on the outputs until the next start request.

Top module: `link_fallback_ctrl`

## Requirements
- R1: The first attempt uses the smaller of `sink_rate_i` and `SYS_MAX_RATE` (default 0x1E) as its rate.
- R2: The first attempt uses the smaller of `sink_lane_i[4:0]` and `MAX_LANES` (default 4) as its lane count. Bits 7:5 of `sink_lane_i` have no effect.
- R3: After a clock-recovery failure, the next attempt keeps the lane count and moves the rate down one grade: 0x1E goes to 0x14, 0x14 to 0x0A, and 0x0A to 0x06.
- R4: After a clock-recovery failure at rate 0x06, the next attempt uses half the lane count, rounded down, and the starting rate. If the halved lane count is zero, the run ends as a fail.
- R5: A clock-recovery failure at any rate code other than 0x1E, 0x14, 0x0A or 0x06 ends the run as a fail at once.
- R6: After an attempt where clock recovery passed and equalization failed, the next attempt keeps the rate and reduces the lanes from 4 to 2 or from 2 to 1. With any other lane count, the run ends as a fail.
- R7: A run makes at most `MAX_ATTEMPTS` (default 6) attempts. If the last permitted attempt fails, the run ends as a fail.
- R8: Every attempt starts with one cycle in which `phy_reset_o` and `drv_reset_o` are high. Then come `SETTLE_CYCLES` idle cycles, and then a one-cycle `train_start_o`. So `train_start_o` rises `SETTLE_CYCLES`+1 cycles after `phy_reset_o`.
- R9: A run ends with a one-cycle `done_o`. On pass, `pass_o`=1 and `final_rate_o`/`final_lanes_o` hold the configuration of the passing attempt. On fail, all three are 0. These values are cleared on the cycle after an accepted start and otherwise stay unchanged until the next start.
- R10: `start_i` has no effect while `busy_o` is high, and `train_done_i` has no effect while the block is not waiting for a training result.
- R11: After reset, `busy_o`, `done_o`, `pass_o`, `phy_reset_o`, `drv_reset_o`, `train_start_o`, `final_rate_o` and `final_lanes_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new fallback run (accepted when idle) |
| sink_rate_i | input | 8 | Rate code reported by the sink |
| sink_lane_i | input | 8 | Lane field reported by the sink; bits 4:0 are used |
| phy_reset_o | output | 1 | PHY reset pulse at the start of each attempt |
| drv_reset_o | output | 1 | Drive-level reset pulse at the start of each attempt |
| train_start_o | output | 1 | Start pulse to the training sequencer |
| train_rate_o | output | 8 | Rate code for the current attempt |
| train_lanes_o | output | 3 | Lane count for the current attempt |
| train_done_i | input | 1 | Training sequencer finished |
| train_cr_ok_i | input | 1 | Clock recovery passed (valid with train_done_i) |
| train_eq_ok_i | input | 1 | Equalization passed (valid with train_done_i) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run passed |
| final_rate_o | output | 8 | Trained rate code of the last passing run |
| final_lanes_o | output | 3 | Trained lane count of the last passing run |

## Verification
The assertions check, on every cycle, the pulse shape of the reset, launch and done strobes and that these strobes never overlap. They also check that the rate and lane count of an attempt never go above the system limits, that results stay stable while idle, and that the attempt count of a run stays within its limit. The order in which rates and lanes are tried, the exit to fail at an unlisted rate or at zero lanes, the exact settle gap, and the rejection of a start during a run all depend on how the sink answers. Only the bench scenarios show these, because the bench plays the part of a sink with chosen rate and lane limits.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned LANE_W = 3;

  localparam logic [7:0] RATE_G0 = 8'h06;
  localparam logic [7:0] RATE_G1 = 8'h0A;
  localparam logic [7:0] RATE_G2 = 8'h14;
  localparam logic [7:0] RATE_G3 = 8'h1E;

  typedef struct packed {
    logic [7:0]        rate;
    logic [LANE_W-1:0] lanes;
  } link_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHY_RST,
    ST_SETTLE,
    ST_LAUNCH,
    ST_WAIT
  } lfc_state_e;

  typedef enum logic [1:0] {
    VERDICT_PASS,
    VERDICT_RETRY,
    VERDICT_FAIL
  } lfc_verdict_e;
endpackage

// File: rtl/lfc_cap_clamp.sv
module lfc_cap_clamp
  import lfc_pkg::*;
#(
  parameter logic [7:0]  SYS_MAX_RATE = 8'h1E,
  parameter int unsigned MAX_LANES    = 4
) (
  input  logic [7:0] sink_rate_i,
  input  logic [7:0] sink_lane_i,
  output link_cfg_t  cfg_o
);
  localparam logic [4:0] LANE_CAP = 5'(MAX_LANES);

  logic [4:0] lane_field;
  assign lane_field = sink_lane_i[4:0];

  always_comb begin
    cfg_o.rate  = (sink_rate_i > SYS_MAX_RATE) ? SYS_MAX_RATE : sink_rate_i;
    cfg_o.lanes = (lane_field > LANE_CAP) ? LANE_W'(MAX_LANES) : lane_field[LANE_W-1:0];
  end
endmodule

// File: rtl/lfc_step_down.sv
module lfc_step_down
  import lfc_pkg::*;
(
  input  link_cfg_t    cur_i,
  input  logic [7:0]   top_rate_i,
  input  logic         cr_ok_i,
  input  logic         eq_ok_i,
  output link_cfg_t    next_o,
  output lfc_verdict_e verdict_o
);
  logic [LANE_W-1:0] half_lanes;
  assign half_lanes = cur_i.lanes >> 1;

  always_comb begin
    next_o    = cur_i;
    verdict_o = VERDICT_RETRY;
    if (cr_ok_i && eq_ok_i) begin
      verdict_o = VERDICT_PASS;
    end else if (!cr_ok_i) begin
      // rate grade first; at the floor trade lanes for the starting rate
      unique case (cur_i.rate)
        RATE_G3: next_o.rate = RATE_G2;
        RATE_G2: next_o.rate = RATE_G1;
        RATE_G1: next_o.rate = RATE_G0;
        RATE_G0: begin
          next_o.rate  = top_rate_i;
          next_o.lanes = half_lanes;
          if (half_lanes == '0) verdict_o = VERDICT_FAIL;
        end
        default: verdict_o = VERDICT_FAIL;
      endcase
    end else begin
      unique case (cur_i.lanes)
        LANE_W'(4): next_o.lanes = LANE_W'(2);
        LANE_W'(2): next_o.lanes = LANE_W'(1);
        default:    verdict_o    = VERDICT_FAIL;
      endcase
    end
  end
endmodule

// File: rtl/lfc_settle_timer.sv
module lfc_settle_timer #(
  parameter int unsigned CYCLES = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'((CYCLES > 0) ? CYCLES - 1 : 0);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (!expired_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_fallback_ctrl.sv
module link_fallback_ctrl
  import lfc_pkg::*;
#(
  parameter logic [7:0]  SYS_MAX_RATE  = 8'h1E,
  parameter int unsigned MAX_LANES     = 4,
  parameter int unsigned MAX_ATTEMPTS  = 6,
  parameter int unsigned SETTLE_CYCLES = 200000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [7:0]   sink_rate_i,
  input  logic [7:0]   sink_lane_i,
  output logic         phy_reset_o,
  output logic         drv_reset_o,
  output logic         train_start_o,
  output logic [7:0]   train_rate_o,
  output logic [2:0]   train_lanes_o,
  input  logic         train_done_i,
  input  logic         train_cr_ok_i,
  input  logic         train_eq_ok_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         pass_o,
  output logic [7:0]   final_rate_o,
  output logic [2:0]   final_lanes_o
);
  localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1);

  lfc_state_e      state_q;
  link_cfg_t       cfg_q, res_q, clamp_cfg, next_cfg;
  logic [7:0]      top_rate_q;
  logic [ATT_W-1:0] att_left_q;
  logic            done_q, pass_q, settle_done;
  lfc_verdict_e    verdict;

  lfc_cap_clamp #(
    .SYS_MAX_RATE(SYS_MAX_RATE),
    .MAX_LANES   (MAX_LANES)
  ) u_clamp (
    .sink_rate_i(sink_rate_i),
    .sink_lane_i(sink_lane_i),
    .cfg_o      (clamp_cfg)
  );

  lfc_step_down u_step (
    .cur_i     (cfg_q),
    .top_rate_i(top_rate_q),
    .cr_ok_i   (train_cr_ok_i),
    .eq_ok_i   (train_eq_ok_i),
    .next_o    (next_cfg),
    .verdict_o (verdict)
  );

  lfc_settle_timer #(
    .CYCLES(SETTLE_CYCLES)
  ) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q != ST_SETTLE),
    .expired_o(settle_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      res_q      <= '0;
      top_rate_q <= '0;
      att_left_q <= '0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cfg_q      <= clamp_cfg;
          top_rate_q <= clamp_cfg.rate;
          att_left_q <= ATT_W'(MAX_ATTEMPTS);
          pass_q     <= 1'b0;
          res_q      <= '0;
          state_q    <= ST_PHY_RST;
        end
        ST_PHY_RST: state_q <= ST_SETTLE;
        ST_SETTLE:  if (settle_done) state_q <= ST_LAUNCH;
        ST_LAUNCH:  state_q <= ST_WAIT;
        ST_WAIT: if (train_done_i) begin
          if (verdict == VERDICT_PASS) begin
            pass_q  <= 1'b1;
            res_q   <= cfg_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (verdict == VERDICT_FAIL || att_left_q == ATT_W'(1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cfg_q      <= next_cfg;
            att_left_q <= att_left_q - 1'b1;
            state_q    <= ST_PHY_RST;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phy_reset_o   = (state_q == ST_PHY_RST);
  assign drv_reset_o   = (state_q == ST_PHY_RST);
  assign train_start_o = (state_q == ST_LAUNCH);
  assign train_rate_o  = cfg_q.rate;
  assign train_lanes_o = cfg_q.lanes;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign pass_o        = pass_q;
  assign final_rate_o  = res_q.rate;
  assign final_lanes_o = res_q.lanes;
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter logic [7:0]  SYS_MAX_RATE = 8'h1E,
  parameter int unsigned MAX_LANES    = 4,
  parameter int unsigned MAX_ATTEMPTS = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       phy_reset_o,
  input logic       train_start_o,
  input logic [7:0] train_rate_o,
  input logic [2:0] train_lanes_o,
  input logic [7:0] final_rate_o,
  input logic [2:0] final_lanes_o
);
  localparam int unsigned CW = $clog2(MAX_ATTEMPTS + 2);
  localparam logic [2:0]  LANE_CAP = 3'(MAX_LANES);

  logic [CW-1:0] att_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 att_cnt <= '0;
    else if (start_i && !busy_o) att_cnt <= '0;
    else if (train_start_o)      att_cnt <= att_cnt + 1'b1;
  end

  p_attempt_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_cnt <= CW'(MAX_ATTEMPTS));

  p_rate_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> train_rate_o <= SYS_MAX_RATE);

  p_lane_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> train_lanes_o <= LANE_CAP);

  p_reset_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_reset_o |=> !phy_reset_o);

  p_launch_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_o |=> !train_start_o);

  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phy_reset_o, train_start_o, done_o}));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_pass_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(final_rate_o) && $stable(final_lanes_o)));

  p_fail_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (final_rate_o == 8'h00 && final_lanes_o == 3'd0));
endmodule

bind link_fallback_ctrl lfc_checker #(
  .SYS_MAX_RATE(SYS_MAX_RATE),
  .MAX_LANES   (MAX_LANES),
  .MAX_ATTEMPTS(MAX_ATTEMPTS)
) u_lfc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .phy_reset_o  (phy_reset_o),
  .train_start_o(train_start_o),
  .train_rate_o (train_rate_o),
  .train_lanes_o(train_lanes_o),
  .final_rate_o (final_rate_o),
  .final_lanes_o(final_lanes_o)
);

// File: tb/link_fallback_ctrl_bench.sv
module link_fallback_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int NROWS      = 14;

  typedef struct packed {
    logic [7:0] s_rate;
    logic [7:0] s_lane;
    logic [7:0] cr_rate_lim;
    logic [2:0] cr_lane_lim;
    logic [2:0] eq_lane_lim;
    logic       e_pass;
    logic [7:0] e_rate;
    logic [2:0] e_lanes;
    logic [3:0] e_att;
  } row_t;

  // sink model: CR ok iff rate<=cr_rate_lim and lanes<=cr_lane_lim; EQ ok iff CR ok and lanes<=eq_lane_lim
  localparam row_t ROWS [NROWS] = '{
    '{8'h14, 8'h04, 8'hFF, 3'd7, 3'd7, 1'b1, 8'h14, 3'd4, 4'd1}, // R1 below cap
    '{8'h1E, 8'h04, 8'h14, 3'd7, 3'd7, 1'b1, 8'h14, 3'd4, 4'd2}, // R3 one step
    '{8'h28, 8'hFF, 8'hFF, 3'd7, 3'd7, 1'b1, 8'h1E, 3'd4, 4'd1}, // R1 R2 clamp
    '{8'h1E, 8'h04, 8'h06, 3'd7, 3'd7, 1'b1, 8'h06, 3'd4, 4'd4}, // R3 full walk
    '{8'h0A, 8'h04, 8'h0A, 3'd2, 3'd7, 1'b1, 8'h0A, 3'd2, 4'd3}, // R4 halve+restore
    '{8'h14, 8'h04, 8'hFF, 3'd7, 3'd1, 1'b1, 8'h14, 3'd1, 4'd3}, // R6 4->2->1
    '{8'h14, 8'h01, 8'hFF, 3'd7, 3'd0, 1'b0, 8'h00, 3'd0, 4'd1}, // R6 eq fail at 1
    '{8'h1E, 8'h04, 8'h00, 3'd7, 3'd7, 1'b0, 8'h00, 3'd0, 4'd6}, // R7 cap
    '{8'h06, 8'h01, 8'h00, 3'd7, 3'd7, 1'b0, 8'h00, 3'd0, 4'd1}, // R4 lanes to zero
    '{8'h19, 8'h04, 8'h00, 3'd7, 3'd7, 1'b0, 8'h00, 3'd0, 4'd1}, // R5 unlisted rate
    '{8'h0A, 8'h02, 8'h00, 3'd7, 3'd7, 1'b0, 8'h00, 3'd0, 4'd4}, // R4 two halvings
    '{8'h14, 8'h02, 8'h0A, 3'd7, 3'd1, 1'b1, 8'h0A, 3'd1, 4'd3}, // R6 after R3 step
    '{8'h14, 8'h03, 8'hFF, 3'd7, 3'd2, 1'b0, 8'h00, 3'd0, 4'd1}, // R6 three lanes
    '{8'h0C, 8'hE3, 8'hFF, 3'd7, 3'd7, 1'b1, 8'h0C, 3'd3, 4'd1}  // R2 upper bits
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] sink_rate = '0, sink_lane = '0;
  logic       tr_done = 1'b0, tr_cr = 1'b0, tr_eq = 1'b0;
  logic       phy_rst, drv_rst, tr_start, busy, done, pass;
  logic [7:0] tr_rate, fin_rate;
  logic [2:0] tr_lanes, fin_lanes;

  int checks = 0, errors = 0;
  int gap_last = 0;
  logic [7:0] seq_rate [8];
  logic [2:0] seq_lanes [8];
  logic pass_after_start;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_fallback_ctrl #(
    .SETTLE_CYCLES(SETTLE)
  ) u_link_fallback_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .sink_rate_i(sink_rate), .sink_lane_i(sink_lane),
    .phy_reset_o(phy_rst), .drv_reset_o(drv_rst), .train_start_o(tr_start),
    .train_rate_o(tr_rate), .train_lanes_o(tr_lanes),
    .train_done_i(tr_done), .train_cr_ok_i(tr_cr), .train_eq_ok_i(tr_eq),
    .busy_o(busy), .done_o(done), .pass_o(pass),
    .final_rate_o(fin_rate), .final_lanes_o(fin_lanes)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int row);
    case (row)
      0:       return "R1";
      1, 3:    return "R3";
      2:       return "R1/R2";
      4, 8, 10: return "R4";
      5, 6, 11, 12: return "R6";
      7:       return "R7";
      9:       return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic run(input logic [7:0] s_rate, input logic [7:0] s_lane,
                     input logic [7:0] crr, input logic [2:0] crl, input logic [2:0] eql,
                     input bit poke,
                     output bit g_pass, output logic [7:0] g_rate,
                     output logic [2:0] g_lanes, output int g_att);
    int cyc = 0, rst_at = 0;
    bit fin = 0;
    g_att = 0;
    @(negedge clk);
    sink_rate = s_rate; sink_lane = s_lane; start = 1'b1;
    while (!fin && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin start = 1'b0; pass_after_start = pass; end
      if (poke && cyc == 3) begin
        start = 1'b1; sink_rate = 8'h06; sink_lane = 8'h01;
      end else if (poke && cyc == 4) begin
        start = 1'b0; sink_rate = s_rate; sink_lane = s_lane;
      end
      if (done) fin = 1;
      else if (phy_rst) rst_at = cyc;
      else if (tr_start) begin
        gap_last = cyc - rst_at;
        if (g_att < 8) begin seq_rate[g_att] = tr_rate; seq_lanes[g_att] = tr_lanes; end
        g_att++;
        tr_cr = (tr_rate <= crr) && (tr_lanes <= crl);
        tr_eq = tr_cr && (tr_lanes <= eql);
        repeat (2) @(negedge clk);
        cyc += 2;
        tr_done = 1'b1;
        @(negedge clk);
        cyc++;
        tr_done = 1'b0; tr_cr = 1'b0; tr_eq = 1'b0;
        if (done) fin = 1;
      end
    end
    if (!fin) chk(1'b0, "R9", "run did not finish", cyc, 0);
    g_pass = pass; g_rate = fin_rate; g_lanes = fin_lanes;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit gp; logic [7:0] gr; logic [2:0] gl; int ga;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !pass && !phy_rst && !drv_rst && !tr_start, "R11", "strobes after reset",
        {busy, done, pass, phy_rst, drv_rst, tr_start}, 0);
    chk(fin_rate == 0 && fin_lanes == 0, "R11", "result after reset", {fin_rate, fin_lanes}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      run(ROWS[i].s_rate, ROWS[i].s_lane, ROWS[i].cr_rate_lim, ROWS[i].cr_lane_lim,
          ROWS[i].eq_lane_lim, 1'b0, gp, gr, gl, ga);
      chk(gp == ROWS[i].e_pass, req_of(i), $sformatf("row %0d pass", i), gp, ROWS[i].e_pass);
      chk(gr == ROWS[i].e_rate, req_of(i), $sformatf("row %0d rate", i), gr, ROWS[i].e_rate);
      chk(gl == ROWS[i].e_lanes, req_of(i), $sformatf("row %0d lanes", i), gl, ROWS[i].e_lanes);
      chk(ga == int'(ROWS[i].e_att), req_of(i), $sformatf("row %0d attempts", i), ga, ROWS[i].e_att);
      if (i == 7) begin
        // R3 R4 R7 order of tried configurations under the cap
        chk(seq_rate[0] == 8'h1E && seq_rate[1] == 8'h14 && seq_rate[2] == 8'h0A &&
            seq_rate[3] == 8'h06 && seq_rate[4] == 8'h1E && seq_rate[5] == 8'h14,
            "R3", "rate sequence", seq_rate[4], 8'h1E);
        chk(seq_lanes[3] == 3'd4 && seq_lanes[4] == 3'd2 && seq_lanes[5] == 3'd2,
            "R4", "lane sequence", seq_lanes[4], 2);
      end
    end

    // R8 settle gap and reset strobe pairing
    run(8'h14, 8'h04, 8'hFF, 3'd7, 3'd7, 1'b0, gp, gr, gl, ga);
    chk(gap_last == SETTLE + 1, "R8", "reset-to-launch gap", gap_last, SETTLE + 1);
    chk(phy_rst == drv_rst, "R8", "drive reset pairing", drv_rst, phy_rst);

    // R9 hold while idle, spurious done ignored (R10)
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      tr_done = (k == 2); tr_cr = (k == 2); tr_eq = (k == 2);
    end
    @(negedge clk);
    tr_done = 1'b0; tr_cr = 1'b0; tr_eq = 1'b0;
    chk(pass && fin_rate == 8'h14 && fin_lanes == 3'd4 && !busy, "R10", "idle hold after stray done",
        fin_rate, 8'h14);

    // R9 clear on start; R10 start during run ignored
    run(8'h1E, 8'h04, 8'h14, 3'd7, 3'd7, 1'b1, gp, gr, gl, ga);
    chk(pass_after_start == 1'b0, "R9", "pass cleared after start", pass_after_start, 0);
    chk(gp && gr == 8'h14 && gl == 3'd4, "R10", "result with start poked mid-run", gr, 8'h14);
    chk(ga == 2, "R10", "attempts with start poked mid-run", ga, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule